// File: doc/BRIEF.md
# Add-With-Carry Instruction Executor

This block carries out the 8-bit add-with-carry instruction family of a small 8-bit CPU. The surrounding core fetches the opcode, presents it on `opcode` with a one-cycle `start` pulse, and drives the current register values, the carry flag and the program counter. The block decodes the opcode into one of three operand sources:
- one of seven registers;
- an immediate byte read at the program counter;
- a byte read at the address held in the H:L register pair.

It adds the operand and the incoming carry to the accumulator. It then returns the new accumulator, a freshly packed flag byte and, for the immediate form, the advanced program counter.

Register forms finish in one machine cycle. The two memory forms issue a single read on a synchronous port with one cycle of latency and finish in two. An opcode outside the family finishes with no writeback and an illegal flag. Results appear with a one-cycle `done` pulse. The write enables `a_we` and `pc_we` show which values the core must take.

Top module: `adc_exec`

## Requirements
- R1: On a legal opcode the written accumulator `a_out` equals (A + operand + carry-in) modulo 256.
- R2: The flag byte `f_out` is packed as zero at bit 7, subtract at bit 6, half-carry at bit 5 and carry at bit 4, with bits 3..0 always 0. The subtract bit is always 0. The zero bit is 1 exactly when `a_out` is 0x00.
- R3: The carry bit (bit 4) is 1 exactly when A + operand + carry-in exceeds 0xFF.
- R4: The half-carry bit (bit 5) is 1 exactly when the low nibble of A plus the low nibble of the operand plus carry-in exceeds 0xF.
- R5: Opcodes 0x88, 0x89, 0x8A, 0x8B, 0x8C, 0x8D and 0x8F take B, C, D, E, H, L and A as the operand. `done` rises in the cycle after `start`, with `mcycles` = 1, no memory read and `pc_we` = 0.
- R6: Opcode 0xCE reads memory at the program counter. It reports `pc_we` = 1 with `pc_out` = PC + 1 modulo 65536, and `mcycles` = 2.
- R7: Opcode 0x8E reads memory at address {H, L}, with H as the upper byte. It reports `mcycles` = 2 and `pc_we` = 0.
- R8: For a memory form, `mem_rd` is high for exactly the one cycle after `start`, with `mem_addr` valid. `mem_rdata` is taken in the following cycle, and `done` rises one cycle after that.
- R9: Any other opcode gives `done` together with `illegal` = 1 in the cycle after `start`, with `a_we` = 0 and `pc_we` = 0.
- R10: `busy` is high while a memory form is in progress, and `start` is ignored while `busy` is high. `done` is a single-cycle pulse per accepted instruction and is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to execute `opcode`; taken only when idle |
| opcode | input | 8 | Instruction opcode |
| a_in | input | 8 | Accumulator value |
| b_in | input | 8 | Register B value |
| c_in | input | 8 | Register C value |
| d_in | input | 8 | Register D value |
| e_in | input | 8 | Register E value |
| h_in | input | 8 | Register H value |
| l_in | input | 8 | Register L value |
| cy_in | input | 1 | Incoming carry flag |
| pc_in | input | 16 | Program counter (points at the immediate byte) |
| busy | output | 1 | Memory form in progress |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completed opcode was not in the family |
| a_we | output | 1 | Accumulator write enable, valid with `done` |
| a_out | output | 8 | New accumulator value |
| f_out | output | 8 | New flag byte |
| pc_we | output | 1 | Program counter write enable, valid with `done` |
| pc_out | output | 16 | New program counter value |
| mcycles | output | 2 | Machine cycles taken by the completed instruction |

## Verification
On every cycle, the assertions check the following:
- the packing of the flag byte and the zero flag;
- the carry and half-carry outputs of the adder, against a comparison form and a bit-4 parity form;
- the single-cycle read strobe and its fixed distance to `done`;
- the absence of writeback on illegal opcodes;
- one-cycle completion of the register forms;
- that `done` and `busy` are never high together.

Only the bench scenarios can show that each opcode picks the right register or address, and that the sum agrees with an independent model across a grid and a nibble-corner set of A, operand and carry-in. They also show the program counter wrap at 0xFFFF, and that a `start` given during a memory read leaves the result unchanged and adds no completion.

// File: rtl/adc_pkg.sv
package adc_pkg;

  localparam int unsigned DW     = 8;
  localparam int unsigned AW     = 16;
  localparam int unsigned NIB    = DW / 2;
  localparam int unsigned FLAG_Z = 7;
  localparam int unsigned FLAG_N = 6;
  localparam int unsigned FLAG_H = 5;
  localparam int unsigned FLAG_C = 4;

  typedef enum logic [1:0] {SRC_REG, SRC_IMM, SRC_HL, SRC_NONE} src_e;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_CAPTURE} st_e;

  typedef struct packed {
    src_e       src;
    logic [2:0] sel;
  } dec_t;

  // Opcode map: 0x88..0x8F register group (0x8E indirect), 0xCE immediate.
  function automatic dec_t decode_op(input logic [7:0] op);
    dec_t d;
    d.sel = op[2:0];
    d.src = SRC_NONE;
    if (op[7:3] == 5'b10001) begin
      d.src = (op[2:0] == 3'b110) ? SRC_HL : SRC_REG;
    end else if (op == 8'hCE) begin
      d.src = SRC_IMM;
    end
    return d;
  endfunction

  function automatic logic [DW:0] add_full(input logic [DW-1:0] a,
                                           input logic [DW-1:0] b,
                                           input logic          cin);
    return {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
  endfunction

  function automatic logic nib_carry(input logic [DW-1:0] a,
                                     input logic [DW-1:0] b,
                                     input logic          cin);
    logic [NIB:0] s;
    s = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
    return s[NIB];
  endfunction

  function automatic logic [DW-1:0] pack_flags(input logic z,
                                               input logic h,
                                               input logic c);
    logic [DW-1:0] f;
    f         = '0;
    f[FLAG_Z] = z;
    f[FLAG_N] = 1'b0;
    f[FLAG_H] = h;
    f[FLAG_C] = c;
    return f;
  endfunction

endpackage

// File: rtl/adc_decode.sv
module adc_decode
  import adc_pkg::*;
(
  input  logic [7:0] opcode,
  output src_e       src,
  output logic [2:0] sel
);

  dec_t d;

  always_comb begin
    d   = decode_op(opcode);
    src = d.src;
    sel = d.sel;
  end

endmodule

// File: rtl/adc_alu.sv
module adc_alu
  import adc_pkg::*;
(
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  input  logic          cin,
  output logic [DW-1:0] result,
  output logic          half,
  output logic          carry,
  output logic [DW-1:0] flags
);

  logic [DW:0] sum;

  always_comb begin
    sum    = add_full(acc, opnd, cin);
    result = sum[DW-1:0];
    carry  = sum[DW];
    half   = nib_carry(acc, opnd, cin);
    flags  = pack_flags(result == '0, half, carry);
  end

endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  src_e src,
  output st_e  state,
  output logic accept,
  output logic commit
);

  st_e nxt;

  always_comb begin
    accept = start && (state == ST_IDLE);
    commit = (accept && (src == SRC_REG || src == SRC_NONE))
             || (state == ST_CAPTURE);
    nxt = state;
    unique case (state)
      ST_IDLE:    if (accept && (src == SRC_IMM || src == SRC_HL)) nxt = ST_FETCH;
      ST_FETCH:   nxt = ST_CAPTURE;
      ST_CAPTURE: nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/adc_exec.sv
module adc_exec
  import adc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] c_in,
  input  logic [DW-1:0] d_in,
  input  logic [DW-1:0] e_in,
  input  logic [DW-1:0] h_in,
  input  logic [DW-1:0] l_in,
  input  logic          cy_in,
  input  logic [AW-1:0] pc_in,
  output logic          busy,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          illegal,
  output logic          a_we,
  output logic [DW-1:0] a_out,
  output logic [DW-1:0] f_out,
  output logic          pc_we,
  output logic [AW-1:0] pc_out,
  output logic [1:0]    mcycles
);

  src_e          dec_src;
  logic [2:0]    dec_sel;
  st_e           st;
  logic          accept_w, commit_w, in_capture;
  logic [DW-1:0] reg_opnd;

  logic [DW-1:0] acc_q;
  logic          cy_q;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] addr_q;
  src_e          src_q;

  // named internal events for the checker
  src_e          eff_src;
  logic          legal_w, src_reg_w;
  logic [DW-1:0] alu_a, alu_b, alu_res, alu_flags;
  logic          alu_cin, half_w, carry_w;
  logic [AW-1:0] pc_base;

  adc_decode u_dec (
    .opcode (opcode),
    .src    (dec_src),
    .sel    (dec_sel)
  );

  adc_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .src    (dec_src),
    .state  (st),
    .accept (accept_w),
    .commit (commit_w)
  );

  always_comb begin
    unique case (dec_sel)
      3'd0:    reg_opnd = b_in;
      3'd1:    reg_opnd = c_in;
      3'd2:    reg_opnd = d_in;
      3'd3:    reg_opnd = e_in;
      3'd4:    reg_opnd = h_in;
      3'd5:    reg_opnd = l_in;
      3'd7:    reg_opnd = a_in;
      default: reg_opnd = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cy_q   <= 1'b0;
      pc_q   <= '0;
      addr_q <= '0;
      src_q  <= SRC_NONE;
    end else if (accept_w) begin
      acc_q  <= a_in;
      cy_q   <= cy_in;
      pc_q   <= pc_in;
      addr_q <= (dec_src == SRC_IMM) ? pc_in : {h_in, l_in};
      src_q  <= dec_src;
    end
  end

  assign in_capture = (st == ST_CAPTURE);
  assign eff_src    = in_capture ? src_q : dec_src;
  assign legal_w    = (eff_src != SRC_NONE);
  assign src_reg_w  = (dec_src == SRC_REG);
  assign alu_a      = in_capture ? acc_q : a_in;
  assign alu_b      = in_capture ? mem_rdata : reg_opnd;
  assign alu_cin    = in_capture ? cy_q : cy_in;
  assign pc_base    = in_capture ? pc_q : pc_in;

  adc_alu u_alu (
    .acc    (alu_a),
    .opnd   (alu_b),
    .cin    (alu_cin),
    .result (alu_res),
    .half   (half_w),
    .carry  (carry_w),
    .flags  (alu_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      illegal <= 1'b0;
      a_we    <= 1'b0;
      pc_we   <= 1'b0;
      a_out   <= '0;
      f_out   <= '0;
      pc_out  <= '0;
      mcycles <= '0;
    end else if (commit_w) begin
      done    <= 1'b1;
      illegal <= !legal_w;
      a_we    <= legal_w;
      pc_we   <= (eff_src == SRC_IMM);
      mcycles <= in_capture ? 2'd2 : 2'd1;
      if (legal_w) begin
        a_out <= alu_res;
        f_out <= alu_flags;
      end
      if (eff_src == SRC_IMM) pc_out <= pc_base + {{(AW-1){1'b0}}, 1'b1};
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      a_we    <= 1'b0;
      pc_we   <= 1'b0;
    end
  end

  assign busy     = (st != ST_IDLE);
  assign mem_rd   = (st == ST_FETCH);
  assign mem_addr = addr_q;

endmodule

// File: rtl/adc_exec_chk.sv
module adc_exec_chk
  import adc_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          mem_rd,
  input logic          done,
  input logic          illegal,
  input logic          a_we,
  input logic          pc_we,
  input logic [DW-1:0] a_out,
  input logic [DW-1:0] f_out,
  input logic [1:0]    mcycles,
  input logic          commit_w,
  input logic          legal_w,
  input logic          src_reg_w,
  input logic [DW-1:0] alu_a,
  input logic [DW-1:0] alu_b,
  input logic          alu_cin,
  input logic [DW-1:0] alu_res,
  input logic          half_w,
  input logic          carry_w
);

  AST_FLAG_PACK: assert property (@(posedge clk) disable iff (!rst_n)
    a_we |-> (!f_out[FLAG_N] && f_out[3:0] == 4'h0)); // R2
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    a_we |-> (f_out[FLAG_Z] == (a_out == '0))); // R2
  AST_CARRY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_w && legal_w) |-> (carry_w == ((alu_res < alu_a) || (alu_res == alu_a && alu_b == 8'hFF && alu_cin)))); // R3
  AST_HALF_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_w && legal_w) |-> (half_w == (alu_a[4] ^ alu_b[4] ^ alu_res[4]))); // R4
  AST_REG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && src_reg_w) |=> (done && a_we && mcycles == 2'd1 && !pc_we)); // R5
  AST_PC_ONLY_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (a_we && mcycles == 2'd2)); // R6
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd); // R8
  AST_READ_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> ##2 (done && a_we)); // R8
  AST_ILLEGAL_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && !a_we && !pc_we)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

endmodule

bind adc_exec adc_exec_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .mem_rd    (mem_rd),
  .done      (done),
  .illegal   (illegal),
  .a_we      (a_we),
  .pc_we     (pc_we),
  .a_out     (a_out),
  .f_out     (f_out),
  .mcycles   (mcycles),
  .commit_w  (commit_w),
  .legal_w   (legal_w),
  .src_reg_w (src_reg_w),
  .alu_a     (alu_a),
  .alu_b     (alu_b),
  .alu_cin   (alu_cin),
  .alu_res   (alu_res),
  .half_w    (half_w),
  .carry_w   (carry_w)
);

// File: tb/adc_exec_bench.sv
`timescale 1ns/1ps
module adc_exec_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  a_in = 0, b_in = 0, c_in = 0, d_in = 0, e_in = 0, h_in = 0, l_in = 0;
  logic        cy_in = 1'b0;
  logic [15:0] pc_in = 16'h0;
  logic        busy, mem_rd, done, illegal, a_we, pc_we;
  logic [15:0] mem_addr, pc_out;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  a_out, f_out;
  logic [1:0]  mcycles;
  logic [7:0]  mem_val = 8'h00;

  always #2.5 clk = ~clk;

  adc_exec u_adc_exec (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in), .e_in(e_in),
    .h_in(h_in), .l_in(l_in), .cy_in(cy_in), .pc_in(pc_in),
    .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .illegal(illegal), .a_we(a_we), .a_out(a_out), .f_out(f_out),
    .pc_we(pc_we), .pc_out(pc_out), .mcycles(mcycles)
  );

  // synchronous memory, one cycle of read latency
  always @(posedge clk) if (mem_rd) mem_rdata <= mem_val;

  typedef struct {
    logic        ill;
    logic [7:0]  a;
    logic [7:0]  f;
    logic        pcw;
    logic [15:0] pc;
    logic [1:0]  mc;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per completion
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbq.size() == 0) begin
        check(0, "R10", "done without pending instruction", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(illegal == e.ill, "R9", "illegal flag", illegal, e.ill);
        if (e.ill) begin
          check(!a_we && !pc_we, "R9", "writeback on illegal", {a_we, pc_we}, 0);
        end else begin
          check(a_we, "R1", "accumulator write enable", a_we, 1);
          check(a_out == e.a, "R1", "sum", a_out, e.a);
          check(f_out == e.f, "R2 R3 R4", "flags", f_out, e.f);
          check(mcycles == e.mc, "R5 R6 R7", "machine cycles", mcycles, e.mc);
          check(pc_we == e.pcw, "R6", "pc write enable", pc_we, e.pcw);
          if (e.pcw) check(pc_out == e.pc, "R6", "pc increment", pc_out, e.pc);
        end
      end
    end
  end

  // driver: computes the expected item, pushes it, drives the request
  task automatic issue(input logic [7:0] op, input logic [7:0] a, input logic [7:0] opnd,
                       input logic cy, input logic [15:0] pc, input logic [7:0] hh,
                       input logic [7:0] ll, input bit poke);
    exp_t e;
    int   sum, nib, alt;
    bit   is_mem, legal;
    logic [7:0] regs[7];
    for (int i = 0; i < 7; i++) regs[i] = opnd ^ 8'(8'h11 * (i + 1));
    legal  = (op >= 8'h88 && op <= 8'h8F) || op == 8'hCE;
    is_mem = (op == 8'h8E) || (op == 8'hCE);
    if (op >= 8'h88 && op <= 8'h8D) regs[op - 8'h88] = opnd;
    if (op != 8'h8C && op != 8'h8D) begin regs[4] = hh; regs[5] = ll; end
    else if (op == 8'h8C) begin regs[5] = ll; end
    else begin regs[4] = hh; end
    if (op == 8'h8F) opnd = a;
    sum = int'(a) + int'(opnd) + int'(cy);
    nib = (int'(a) % 16) + (int'(opnd) % 16) + int'(cy);
    if (!cy) begin
      alt = ((a & opnd) | ((a ^ opnd) & ~(a + opnd))) & 8'h08;
      check((alt != 0) == (nib > 15), "R4", "half-carry model forms agree", alt, nib);
    end
    e.ill = !legal;
    e.a   = 8'(sum % 256);
    e.f   = ((sum % 256) == 0 ? 8'h80 : 8'h00) | (nib > 15 ? 8'h20 : 8'h00)
          | (sum > 255 ? 8'h10 : 8'h00);
    e.pcw = (op == 8'hCE);
    e.pc  = pc + 16'd1;
    e.mc  = is_mem ? 2'd2 : 2'd1;
    sbq.push_back(e);
    mem_val = opnd;
    opcode = op; a_in = a; cy_in = cy; pc_in = pc;
    b_in = regs[0]; c_in = regs[1]; d_in = regs[2]; e_in = regs[3];
    h_in = regs[4]; l_in = regs[5];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (is_mem) begin
      check(mem_rd && busy, "R8", "read strobe after start", {mem_rd, busy}, 2'b11);
      if (op == 8'hCE) check(mem_addr == pc, "R6", "immediate address", mem_addr, pc);
      else check(mem_addr == {regs[4], regs[5]}, "R7", "indirect address", mem_addr, {regs[4], regs[5]});
      if (poke) begin
        start = 1'b1; opcode = 8'h88; a_in = ~a; b_in = 8'h5A; cy_in = ~cy;
      end
      @(negedge clk);
      start = 1'b0;
      check(!mem_rd && busy, "R8", "strobe single cycle", {mem_rd, busy}, 2'b01);
    end else if (legal) begin
      check(!mem_rd, "R5", "no read for register form", mem_rd, 0);
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "R10", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops[9];
    logic [7:0] corners[10];
    logic [7:0] bad[6];
    ops = '{8'h88, 8'h89, 8'h8A, 8'h8B, 8'h8C, 8'h8D, 8'h8F, 8'hCE, 8'h8E};
    corners = '{8'h00, 8'h01, 8'h07, 8'h08, 8'h0F, 8'h7F, 8'h80, 8'h88, 8'hF0, 8'hFF};
    bad = '{8'h00, 8'h80, 8'h87, 8'h90, 8'hCF, 8'hFF};
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_rd && !a_we && !pc_we && !illegal, "R10", "reset state",
          {busy, done, mem_rd, a_we, pc_we, illegal}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R3 R4 R5 R6 R7: grid over accumulator, operand and carry for each opcode
    for (int k = 0; k < 9; k++)
      for (int a = 0; a < 256; a += 3)
        for (int b = 0; b < 256; b += 7)
          for (int cy = 0; cy < 2; cy++)
            issue(ops[k], 8'(a), 8'(b), 1'(cy), 16'(a * 256 + b), 8'(b + 3), 8'(a ^ 8'hC3), 0);
    // R4 R3: nibble and byte corner values
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          for (int cy = 0; cy < 2; cy++)
            issue(k == 0 ? 8'h88 : 8'hCE, corners[i], corners[j], 1'(cy), 16'h1234, 8'h40, 8'h02, 0);
    // R6: program counter wraps
    issue(8'hCE, 8'h10, 8'h20, 1'b0, 16'hFFFF, 8'h00, 8'h00, 0);
    // R7: indirect at the top of memory
    issue(8'h8E, 8'hFF, 8'h00, 1'b1, 16'h0100, 8'hFF, 8'hFF, 0);
    // R9: opcodes outside the family
    for (int i = 0; i < 6; i++) issue(bad[i], 8'h42, 8'h17, 1'b1, 16'h2000, 8'h11, 8'h22, 0);
    // R10: start during a memory read is ignored
    issue(8'h8E, 8'h3C, 8'hC4, 1'b0, 16'h0400, 8'h12, 8'h34, 1);
    issue(8'hCE, 8'h0F, 8'h00, 1'b1, 16'h7FFF, 8'h00, 8'h00, 1);
    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R10", "pending items after run", sbq.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule